// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address of every beat in a synchronous DRAM burst, one address per clock. A controller pulses a start input with the first column, a burst length code and a wrap-type bit. The block then presents the first beat's column. Each clock with the advance input high moves it to the next beat, until the final beat has been consumed. The generator also raises a flag on the final beat and a busy flag for the whole burst.

Two beat orderings are available inside the aligned burst window. Sequential wrap counts the low address bits upward modulo the burst length. Interleaved wrap XORs the beat number into the low start bits. A full-page option walks the whole row in sequential order, wraps around from the top column to column zero, and keeps going until a terminate input stops it. Asking for full page together with interleaved wrap raises an error flag, and the burst then runs as a sequential full-page burst. A new start is accepted on any clock and aborts whatever burst is running. This allows a fresh random column on every cycle.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, col_o is 0 and busy_o, last_o and mode_err_o are all 0.
- R2: When start_i is high at a clock edge, col_o after that edge equals start_col_i and busy_o is 1, even if a burst was already running (abort and restart).
- R3: len_code_i selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. busy_o falls at the edge that advances past beat BL-1.
- R4: With interleave_i low, the column of beat n keeps the upper bits of start_col_i and has low log2(BL) bits equal to (start low bits + n) modulo BL.
- R5: With interleave_i high, the column of beat n keeps the upper bits of start_col_i and has low log2(BL) bits equal to start low bits XOR n.
- R6: last_o is 1 exactly while busy_o is 1 and the current beat is beat BL-1. It is never 1 in a full-page burst.
- R7: With full_page_i high at start, len_code_i is ignored and beat n has column (start_col_i + n) modulo 2^COL_W. The burst runs with no end until term_i or a new start.
- R8: A start with both full_page_i and interleave_i high sets mode_err_o, and the burst runs as a sequential full-page burst. mode_err_o keeps its value until the next start.
- R9: During a burst, a clock with advance_i low leaves col_o, last_o and busy_o unchanged.
- R10: term_i high without start_i clears busy_o at that edge. start_i has priority over term_i at the same edge.
- R11: While busy_o is 0, advance_i has no effect: col_o keeps its value and busy_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a new burst (aborts any running burst) |
| start_col_i | input | COL_W | First column of the burst |
| len_code_i | input | 2 | Burst length code: 0=1, 1=2, 2=4, 3=8 beats |
| interleave_i | input | 1 | 1 = interleaved ordering, 0 = sequential |
| full_page_i | input | 1 | 1 = full-row burst until terminated |
| advance_i | input | 1 | Move to the next beat |
| term_i | input | 1 | Stop the current burst |
| col_o | output | COL_W | Column of the current beat |
| last_o | output | 1 | Current beat is the final beat of the burst |
| busy_o | output | 1 | A burst is in progress |
| mode_err_o | output | 1 | Last start asked for full page with interleaved wrap |

## Verification
The hardest case to reach from the ports is the full-page wrap from column 255 to column 0. It needs a long run of advances with no end flag, and it needs starts near the top of the row. The bench therefore starts full-page bursts at high columns and advances several hundred beats before terminating. It repeats this with the illegal interleaved request. Abort-on-start is reached by issuing a new start in the middle of a burst and on its final beat.

// File: rtl/burst_pkg.sv
// Package: shared burst length encoding and the derivation of the
// in-window address mask from a length code.
// Assumes: column width of at least 3 bits, so an 8-beat window fits.
package burst_pkg;

    typedef enum logic [1:0] {
        BLEN_1 = 2'd0,
        BLEN_2 = 2'd1,
        BLEN_4 = 2'd2,
        BLEN_8 = 2'd3
    } blen_code_e;

    // Return a mask covering the low bits that change within a burst.
    function automatic logic [7:0] window_mask(input blen_code_e code);
        logic [7:0] m;
        m = (8'd1 << code) - 8'd1;
        return m;
    endfunction

endpackage

// File: rtl/burst_cfg_decode.sv
// Module: burst_cfg_decode
// Turns the request fields into the mask of bits that move inside the
// burst, the effective wrap type and the illegal-mode flag.
// Assumes: full page means the whole column range moves; interleave is
// dropped when full page is requested.
module burst_cfg_decode
    import burst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [1:0]       len_code_i,
    input  logic             interleave_i,
    input  logic             full_page_i,
    output logic [COL_W-1:0] mask_o,
    output logic             ilv_o,
    output logic             err_o
);

    localparam logic [COL_W-1:0] ALL_ONES = '1;

    logic [7:0] small_mask;

    // Pick the window mask for the coded length, or every bit for full page.
    always_comb begin
        small_mask = window_mask(blen_code_e'(len_code_i));
        if (full_page_i) begin
            mask_o = ALL_ONES;
        end else begin
            mask_o = COL_W'(small_mask);
        end
    end

    // Interleave is legal only outside full page; flag the bad pairing.
    always_comb begin
        ilv_o = interleave_i & ~full_page_i;
        err_o = interleave_i & full_page_i;
    end

endmodule

// File: rtl/burst_beat_ctrl.sv
// Module: burst_beat_ctrl
// Beat counter and busy state of a burst. Start wins over terminate, which
// wins over advance. The final beat is the one whose number equals the
// window mask; a full-page burst has no final beat.
// Assumes: mask_i and full_i are stable during a burst.
module burst_beat_ctrl #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             term_i,
    input  logic             advance_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             full_i,
    output logic [COL_W-1:0] beat_o,
    output logic             busy_o,
    output logic             last_o
);

    logic [COL_W-1:0] beat_q;
    logic             busy_q;
    logic             at_end;

    // Detect the final beat of a bounded burst.
    always_comb begin
        at_end = busy_q & ~full_i & (beat_q == mask_i);
    end

    // Sequence the beats: restart, stop, step or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
            busy_q <= 1'b0;
        end else if (start_i) begin
            beat_q <= '0;
            busy_q <= 1'b1;
        end else if (term_i) begin
            busy_q <= 1'b0;
        end else if (advance_i && busy_q) begin
            if (at_end) begin
                busy_q <= 1'b0;
            end else begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // Drive the outputs from state.
    always_comb begin
        beat_o = beat_q;
        busy_o = busy_q;
        last_o = at_end;
    end

endmodule

// File: rtl/burst_col_calc.sv
// Module: burst_col_calc
// Forms the column of a beat: the bits outside the mask come from the base
// column, and the bits inside come from either the sum or the XOR of base
// and beat number.
// Assumes: purely combinational; the beat number stays below mask+1.
module burst_col_calc #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] seq_low;
    logic [COL_W-1:0] ilv_low;

    // Build both orderings and merge the chosen one with the fixed bits.
    always_comb begin
        seq_low = base_i + beat_i;
        ilv_low = base_i ^ beat_i;
        col_o   = (base_i & ~mask_i) | ((ilv_i ? ilv_low : seq_low) & mask_i);
    end

endmodule

// File: rtl/sdram_burst_colgen.sv
// Module: sdram_burst_colgen (top)
// Burst column address generator. On start it captures the base column and
// the decoded mode, then produces one column per advance. It supports
// sequential, interleaved and full-page bursts.
// Assumes: synchronous active-low reset; a start may arrive on any clock.
module sdram_burst_colgen #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [1:0]       len_code_i,
    input  logic             interleave_i,
    input  logic             full_page_i,
    input  logic             advance_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             last_o,
    output logic             busy_o,
    output logic             mode_err_o
);

    logic [COL_W-1:0] dec_mask;
    logic             dec_ilv;
    logic             dec_err;

    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    logic             ilv_q;
    logic             full_q;
    logic             err_q;
    logic [COL_W-1:0] beat;

    burst_cfg_decode #(.COL_W(COL_W)) cfg_i (
        .len_code_i   (len_code_i),
        .interleave_i (interleave_i),
        .full_page_i  (full_page_i),
        .mask_o       (dec_mask),
        .ilv_o        (dec_ilv),
        .err_o        (dec_err)
    );

    // Capture the burst configuration on each start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            ilv_q  <= 1'b0;
            full_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (start_i) begin
            base_q <= start_col_i;
            mask_q <= dec_mask;
            ilv_q  <= dec_ilv;
            full_q <= full_page_i;
            err_q  <= dec_err;
        end
    end

    burst_beat_ctrl #(.COL_W(COL_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .term_i    (term_i),
        .advance_i (advance_i),
        .mask_i    (mask_q),
        .full_i    (full_q),
        .beat_o    (beat),
        .busy_o    (busy_o),
        .last_o    (last_o)
    );

    burst_col_calc #(.COL_W(COL_W)) calc_i (
        .base_i (base_q),
        .beat_i (beat),
        .mask_i (mask_q),
        .ilv_i  (ilv_q),
        .col_o  (col_o)
    );

    // Expose the mode error flag.
    always_comb begin
        mode_err_o = err_q;
    end

endmodule

// File: rtl/sdram_burst_colgen_chk.sv
// Module: sdram_burst_colgen_chk
// Checker bound to the top. It watches the ports and the captured window
// mask and checks the burst sequencing rules over time.
// Assumes: connected through the bind below.
module sdram_burst_colgen_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             interleave_i,
    input logic             full_page_i,
    input logic             advance_i,
    input logic             term_i,
    input logic [COL_W-1:0] col_o,
    input logic             last_o,
    input logic             busy_o,
    input logic             mode_err_o,
    input logic [COL_W-1:0] mask_q,
    input logic             full_q
);

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_o && col_o == $past(start_col_i))); // R2

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && advance_i && !start_i && !term_i) |=> !busy_o); // R3

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i) |=> ((col_o & ~mask_q) == ($past(col_o) & ~mask_q))); // R4

    AST_NO_LAST_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full_q |-> !last_o); // R6

    AST_LAST_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> busy_o); // R6

    AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && full_page_i && interleave_i) |=> mode_err_o); // R8

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !advance_i && !start_i && !term_i) |=> ($stable(col_o) && busy_o)); // R9

    AST_TERM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (term_i && !start_i) |=> !busy_o); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> (!busy_o && $stable(col_o))); // R11

endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_col_i  (start_col_i),
    .interleave_i (interleave_i),
    .full_page_i  (full_page_i),
    .advance_i    (advance_i),
    .term_i       (term_i),
    .col_o        (col_o),
    .last_o       (last_o),
    .busy_o       (busy_o),
    .mode_err_o   (mode_err_o),
    .mask_q       (mask_q),
    .full_q       (full_q)
);

// File: tb/sdram_burst_colgen_tb_top.sv
// Bench: directed tests for the burst column generator, one task per scenario.
module sdram_burst_colgen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start_i;
    logic [COL_W-1:0] start_col_i;
    logic [1:0]       len_code_i;
    logic             interleave_i;
    logic             full_page_i;
    logic             advance_i;
    logic             term_i;
    logic [COL_W-1:0] col_o;
    logic             last_o;
    logic             busy_o;
    logic             mode_err_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_burst_colgen #(.COL_W(COL_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_col_i  (start_col_i),
        .len_code_i   (len_code_i),
        .interleave_i (interleave_i),
        .full_page_i  (full_page_i),
        .advance_i    (advance_i),
        .term_i       (term_i),
        .col_o        (col_o),
        .last_o       (last_o),
        .busy_o       (busy_o),
        .mode_err_o   (mode_err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected column from the requirement formulas (R4, R5, R7, R8).
    function automatic logic [7:0] exp_col(input logic [7:0] s, input int code,
                                           input bit ilv, input bit full, input int n);
        logic [7:0] m, nn, low;
        m   = full ? 8'hFF : 8'((1 << code) - 1);
        nn  = 8'(n);
        low = (ilv && !full) ? (s ^ nn) : (s + nn);
        return (s & ~m) | (low & m);
    endfunction

    // Advance one clock; inputs change and outputs are sampled 1 time unit after the edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        start_i = 0; advance_i = 0; term_i = 0;
    endtask

    task automatic do_start(input logic [7:0] s, input int code, input bit ilv, input bit full);
        start_i = 1; start_col_i = s; len_code_i = 2'(code);
        interleave_i = ilv; full_page_i = full; advance_i = 0; term_i = 0;
        tick();
        start_i = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; idle_inputs(); start_col_i = 0; len_code_i = 0;
        interleave_i = 0; full_page_i = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        chk(col_o == 0, "R1 col", int'(col_o), 0);
        chk(!busy_o && !last_o && !mode_err_o, "R1 flags",
            int'({busy_o, last_o, mode_err_o}), 0);
    endtask

    // Every start column, every length, both wraps, advancing every clock.
    task automatic t_all_bursts();
        for (int ilv = 0; ilv < 2; ilv++) begin
            for (int code = 0; code < 4; code++) begin
                for (int s = 0; s < 256; s++) begin
                    int bl;
                    bl = 1 << code;
                    do_start(8'(s), code, bit'(ilv), 1'b0);
                    advance_i = 1;
                    for (int n = 0; n < bl; n++) begin
                        if (n == 0)
                            chk(col_o == 8'(s), "R2 first beat", int'(col_o), s);
                        if (ilv == 1)
                            chk(col_o == exp_col(8'(s), code, 1, 0, n), "R5 interleaved beat",
                                int'(col_o), int'(exp_col(8'(s), code, 1, 0, n)));
                        else
                            chk(col_o == exp_col(8'(s), code, 0, 0, n), "R4 sequential beat",
                                int'(col_o), int'(exp_col(8'(s), code, 0, 0, n)));
                        chk(last_o == (n == bl - 1), "R6 last flag", int'(last_o), int'(n == bl - 1));
                        chk(busy_o, "R3 busy during burst", int'(busy_o), 1);
                        tick();
                    end
                    advance_i = 0;
                    chk(!busy_o, "R3 burst length end", int'(busy_o), 0);
                end
            end
        end
    endtask

    // Stalls inside a burst hold everything.
    task automatic t_hold();
        do_start(8'h35, 3, 1'b0, 1'b0);
        advance_i = 1; tick(); tick();
        advance_i = 0;
        for (int k = 0; k < 4; k++) begin
            tick();
            chk(col_o == exp_col(8'h35, 3, 0, 0, 2) && busy_o && !last_o, "R9 hold",
                int'(col_o), int'(exp_col(8'h35, 3, 0, 0, 2)));
        end
        term_i = 1; tick(); term_i = 0;
    endtask

    // New start mid-burst and on the final beat.
    task automatic t_abort();
        do_start(8'h10, 3, 1'b0, 1'b0);
        advance_i = 1; tick(); tick();
        start_i = 1; start_col_i = 8'hA6; len_code_i = 2; interleave_i = 1;
        tick(); start_i = 0;
        chk(col_o == 8'hA6 && busy_o, "R2 abort restart", int'(col_o), 8'hA6);
        tick(); tick(); tick();
        chk(last_o && col_o == exp_col(8'hA6, 2, 1, 0, 3), "R2 restarted burst last beat",
            int'(col_o), int'(exp_col(8'hA6, 2, 1, 0, 3)));
        start_i = 1; start_col_i = 8'h03; len_code_i = 1; interleave_i = 0;
        tick(); start_i = 0;
        chk(col_o == 8'h03 && busy_o && !last_o, "R2 start on final beat", int'(col_o), 3);
        tick();
        chk(col_o == 8'h02 && last_o, "R4 BL2 wrap", int'(col_o), 2);
        tick(); advance_i = 0;
        chk(!busy_o, "R3 BL2 end", int'(busy_o), 0);
    endtask

    // Full page: long walk through the wrap, then terminate.
    task automatic t_full_page(input logic [7:0] s, input bit ilv);
        do_start(s, 1, ilv, 1'b1);
        chk(mode_err_o == ilv, "R8 error flag", int'(mode_err_o), int'(ilv));
        advance_i = 1;
        for (int n = 0; n < 300; n++) begin
            chk(col_o == exp_col(s, 1, ilv, 1, n), ilv ? "R8 runs sequential" : "R7 full page beat",
                int'(col_o), int'(exp_col(s, 1, ilv, 1, n)));
            chk(busy_o && !last_o, "R6 no last in full page", int'({busy_o, last_o}), 2);
            tick();
        end
        term_i = 1; tick(); term_i = 0;
        chk(!busy_o, "R10 terminate", int'(busy_o), 0);
        chk(mode_err_o == ilv, "R8 flag holds", int'(mode_err_o), int'(ilv));
        advance_i = 0;
    endtask

    // Terminate versus start priority, and the error clearing on a legal start.
    task automatic t_term_prio();
        do_start(8'h40, 3, 1'b0, 1'b0);
        advance_i = 1; tick();
        start_i = 1; term_i = 1; start_col_i = 8'h77; len_code_i = 2; interleave_i = 0;
        full_page_i = 0;
        tick(); start_i = 0; term_i = 0;
        chk(busy_o && col_o == 8'h77, "R10 start beats term", int'(col_o), 8'h77);
        chk(!mode_err_o, "R8 flag cleared by legal start", int'(mode_err_o), 0);
        term_i = 1; tick(); term_i = 0; advance_i = 0;
        chk(!busy_o, "R10 term mid burst", int'(busy_o), 0);
    endtask

    // Advance while idle changes nothing.
    task automatic t_idle_adv();
        logic [7:0] held;
        held = col_o;
        advance_i = 1;
        for (int k = 0; k < 5; k++) begin
            tick();
            chk(!busy_o && col_o == held, "R11 idle advance", int'(col_o), int'(held));
        end
        advance_i = 0;
    endtask

    initial begin
        t_reset();
        t_all_bursts();
        t_hold();
        t_abort();
        t_idle_adv();
        t_full_page(8'hF9, 1'b0);
        t_full_page(8'hFE, 1'b1);
        t_term_prio();
        t_idle_adv();
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule